// File: doc/BRIEF.md
# Wake-Up Frame Pattern Matcher

This block watches the start of every received Ethernet frame and decides whether the frame is one of up to eight programmed wake-up frames. Each pattern is not stored as raw bytes. It is a length, a 32-bit CRC, and one bit per frame byte in a shared byte-enable memory. While a frame streams in, one byte per valid cycle, every pattern runs its own CRC accumulator over the frame bytes. Bytes that the pattern does not select are replaced by zero. When a pattern's CRC span is complete, the result is compared with that pattern's programmed CRC.

At end of frame the block raises a one-cycle wake pulse if any pattern matched and detection is enabled. It also ORs the matching patterns into a sticky one-hot vector, which stays set until software clears it through the register port. Software computes each CRC offline from the masked pattern. It keeps the global enable clear while no pattern is programmed, because an empty byte-enable memory can still produce a CRC equal to some stored value.

Top module: `wake_pattern_matcher`

## Requirements
- R1: After reset the wake output is low, the matched vector is all zero, detection is disabled, and all lengths, CRCs and byte enables are zero.
- R2: A pattern p matches a frame when the CRC of frame bytes 0 to span-1 equals its programmed CRC. Bytes whose enable bit for p is clear are replaced by 0x00. The CRC uses the reflected polynomial 0xEDB88320, is seeded with 0xFFFFFFFF, and its final value is complemented. On a match with detection enabled, wake_o is high for exactly the one cycle after the end-of-frame byte is accepted, and bit p of matched_o is set in that same cycle.
- R3: Byte-enable word w (0 to 15) covers frame bytes 8w to 8w+7. Frame byte 8w+k uses the 8-bit lane at word bits [(7-k)*8+7:(7-k)*8], so the earliest byte is in the most significant lane, and bit p of that lane enables the byte for pattern p. Register address 0x20+2w writes word bits 31:0 and address 0x21+2w writes word bits 63:32.
- R4: The CRC span of a pattern is its length rounded up to a multiple of 8 bytes. A frame that ends before the span is complete gives no match for that pattern.
- R5: A pattern whose length register is zero never matches, whatever its CRC register holds.
- R6: While the enable bit is clear, an end of frame produces no wake pulse and leaves matched_o unchanged.
- R7: matched_o bits accumulate across frames, and clear to zero only on a write to address 0x01.
- R8: Frame bytes beyond byte 127 take no part in matching. A length value above 128 acts as 128.
- R9: A start marker restarts every accumulator. A frame that was not ended before the next start marker contributes no match.
- R10: Register writes: address 0x00 bit 0 is the enable; address 0x01 clears matched_o; address 0x08+p takes the 8-bit length of pattern p; address 0x10+p takes the 32-bit CRC of pattern p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register write address |
| reg_wdata_i | input | 32 | Register write data |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Current byte is the first byte of a frame |
| rx_eof_i | input | 1 | Current byte is the last byte of a frame |
| rx_data_i | input | 8 | Receive byte |
| wake_o | output | 1 | One-cycle wake pulse after a matching frame ends |
| matched_o | output | 8 | Sticky one-hot matched-pattern vector |

## Verification
All eight slots are loaded with random masks, random bytes and random lengths. Each slot then gets a frame built from its own bytes, which separates a correct per-pattern lane and bit position in the enable memory from a transposed or mirrored one. Frames that corrupt one selected byte must miss, and frames that change only unselected bytes must still hit; together they tell masking-to-zero apart from plain or unmasked CRC. Directed frames that stop one byte short of the rounded span, slots with zero length, lengths of 128 and above with 200-byte frames, and a frame abandoned by a fresh start marker probe the span, saturation and restart rules. Random frames that mix matches, garbage and truncations, with occasional clears and a disabled interval, check accumulation and gating against a reference model.

// File: rtl/wpm_pkg.sv
package wpm_pkg;
  localparam int NUM_PAT   = 8;
  localparam int MAX_BYTES = 128;
  localparam int BPW       = 8;                      // frame bytes per enable word
  localparam int NUM_WORDS = MAX_BYTES / BPW;
  localparam int WORD_W    = BPW * NUM_PAT;
  localparam int IDX_W     = $clog2(MAX_BYTES + 1);
  localparam int WIDX_W    = $clog2(NUM_WORDS);
  localparam int PIDX_W    = $clog2(NUM_PAT);
  localparam int LEN_W     = 8;
  localparam int CRC_W     = 32;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 6;
  localparam int HALVES    = WORD_W / REG_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CLR   = 6'h01;
  localparam logic [2:0]        G_LEN   = 3'b001;
  localparam logic [2:0]        G_CRC   = 3'b010;

  function automatic logic [CRC_W-1:0] crc32_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
    logic [CRC_W-1:0] r;
    r = c ^ {{(CRC_W-8){1'b0}}, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/wpm_regs.sv
module wpm_regs
  import wpm_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              reg_we_i,
  input  logic [ADDR_W-1:0]                 reg_addr_i,
  input  logic [REG_W-1:0]                  reg_wdata_i,
  output logic                              en_o,
  output logic                              clr_o,
  output logic [NUM_PAT-1:0][LEN_W-1:0]     len_o,
  output logic [NUM_PAT-1:0][CRC_W-1:0]     crc_o,
  output logic                              be_we_o,
  output logic [WIDX_W-1:0]                 be_word_o,
  output logic                              be_hi_o,
  output logic [REG_W-1:0]                  be_data_o
);
  logic [2:0]        grp;
  logic [PIDX_W-1:0] pidx;

  assign grp  = reg_addr_i[ADDR_W-1:3];
  assign pidx = reg_addr_i[PIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  en_o <= 1'b0;
    else if (reg_we_i && reg_addr_i == A_CTRL)    en_o <= reg_wdata_i[0];
  end

  assign clr_o = reg_we_i && (reg_addr_i == A_CLR);

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_o[p] <= '0;
        crc_o[p] <= '0;
      end else if (reg_we_i && pidx == PIDX_W'(p)) begin
        if (grp == G_LEN) len_o[p] <= reg_wdata_i[LEN_W-1:0];
        if (grp == G_CRC) crc_o[p] <= reg_wdata_i[CRC_W-1:0];
      end
    end
  end

  assign be_we_o   = reg_we_i && reg_addr_i[ADDR_W-1];
  assign be_word_o = reg_addr_i[WIDX_W:1];
  assign be_hi_o   = reg_addr_i[0];
  assign be_data_o = reg_wdata_i;
endmodule

// File: rtl/wpm_be_mem.sv
module wpm_be_mem
  import wpm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [WIDX_W-1:0]    word_i,
  input  logic                 hi_i,
  input  logic [REG_W-1:0]     data_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_PAT-1:0]   en_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [WIDX_W-1:0] rd_word;
  logic [2:0]        rd_lane;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '0;
      else if (we_i && word_i == WIDX_W'(w)) begin
        if (hi_i) mem_q[w][HALVES*REG_W-1 -: REG_W] <= data_i;
        else      mem_q[w][REG_W-1:0]               <= data_i;
      end
    end
  end

  // earliest byte of a word sits in the top lane
  assign rd_word = idx_i[WIDX_W+2:3];
  assign rd_lane = 3'(BPW - 1) - idx_i[2:0];

  always_comb begin
    if (idx_i < IDX_W'(MAX_BYTES)) en_o = mem_q[rd_word][rd_lane*NUM_PAT +: NUM_PAT];
    else                           en_o = '0;
  end
endmodule

// File: rtl/wpm_crc_lane.sv
module wpm_crc_lane
  import wpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              sof_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        data_i,
  input  logic              en_bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CRC_W-1:0]  crc_ref_i,
  output logic              hits_o       // frame hit including current byte
);
  logic [IDX_W-1:0] len_eff, span;
  logic [CRC_W-1:0] acc_q, base, nxt;
  logic [7:0]       masked;
  logic             in_span, last, hit_now, frame_hit_q;

  assign len_eff = (len_i > LEN_W'(MAX_BYTES)) ? IDX_W'(MAX_BYTES) : IDX_W'(len_i);
  assign span    = (len_eff + IDX_W'(BPW-1)) & ~IDX_W'(BPW-1);
  assign in_span = acc_i && (idx_i < span);
  assign masked  = en_bit_i ? data_i : 8'h00;
  assign base    = sof_i ? CRC_SEED : acc_q;
  assign nxt     = crc32_byte(base, masked);
  assign last    = in_span && (idx_i == span - IDX_W'(1));
  assign hit_now = last && (~nxt == crc_ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= CRC_SEED;
    else if (in_span) acc_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frame_hit_q <= 1'b0;
    else if (acc_i) frame_hit_q <= (frame_hit_q && !sof_i) || hit_now;
  end

  assign hits_o = (frame_hit_q && !sof_i) || hit_now;

  p_zero_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i == '0) |-> !hit_now);
  p_hit_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_now |-> (idx_i < IDX_W'(MAX_BYTES)));
endmodule

// File: rtl/wake_pattern_matcher.sv
module wake_pattern_matcher
  import wpm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [5:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic               rx_valid_i,
  input  logic               rx_sof_i,
  input  logic               rx_eof_i,
  input  logic [7:0]         rx_data_i,
  output logic               wake_o,
  output logic [7:0]         matched_o
);
  logic                          en, clr;
  logic [NUM_PAT-1:0][LEN_W-1:0] len;
  logic [NUM_PAT-1:0][CRC_W-1:0] crc;
  logic                          be_we, be_hi;
  logic [WIDX_W-1:0]             be_word;
  logic [REG_W-1:0]              be_data;
  logic [NUM_PAT-1:0]            en_bits, hits;
  logic [IDX_W-1:0]              byte_cnt_q, cur_idx;
  logic                          in_frame_q, accept, eof_acc, lane_acc;
  logic [NUM_PAT-1:0]            matched_q;
  logic                          wake_q;

  wpm_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .en_o(en), .clr_o(clr), .len_o(len), .crc_o(crc),
    .be_we_o(be_we), .be_word_o(be_word), .be_hi_o(be_hi), .be_data_o(be_data)
  );

  assign accept   = rx_valid_i && (rx_sof_i || in_frame_q);
  assign eof_acc  = accept && rx_eof_i;
  assign cur_idx  = rx_sof_i ? '0 : byte_cnt_q;
  assign lane_acc = accept && (cur_idx < IDX_W'(MAX_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt_q <= '0;
      in_frame_q <= 1'b0;
    end else if (accept) begin
      in_frame_q <= !rx_eof_i;
      byte_cnt_q <= (cur_idx == IDX_W'(MAX_BYTES)) ? cur_idx : cur_idx + IDX_W'(1);
    end
  end

  wpm_be_mem u_be_mem (
    .clk_i, .rst_ni, .we_i(be_we), .word_i(be_word), .hi_i(be_hi),
    .data_i(be_data), .idx_i(cur_idx), .en_o(en_bits)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_lane
    wpm_crc_lane u_lane (
      .clk_i, .rst_ni, .acc_i(lane_acc), .sof_i(rx_sof_i), .idx_i(cur_idx),
      .data_i(rx_data_i), .en_bit_i(en_bits[p]), .len_i(len[p]),
      .crc_ref_i(crc[p]), .hits_o(hits[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q    <= 1'b0;
      matched_q <= '0;
    end else begin
      wake_q    <= eof_acc && en && (|hits);
      matched_q <= (clr ? '0 : matched_q) | ((eof_acc && en) ? hits : '0);
    end
  end

  assign wake_o    = wake_q;
  assign matched_o = matched_q;

  p_wake_after_eof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(eof_acc));
  p_wake_has_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (|matched_o));
  p_wake_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(en));
  p_hold_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(en) && !$past(clr)) |-> $stable(matched_o));
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr) |-> ((matched_o & $past(matched_o)) == $past(matched_o)));
  p_cnt_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_cnt_q <= IDX_W'(MAX_BYTES));
endmodule

// File: tb/wake_pattern_matcher_tb.sv
`timescale 1ns/1ps
module wake_pattern_matcher_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        wake_o;
  logic [7:0]  matched_o;

  wake_pattern_matcher u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit [63:0] be_m [16];
  int        len_m [8];
  bit [31:0] crc_m [8];
  bit [7:0]  pat [8][256];
  bit [7:0]  frame [256];
  bit        en_m = 0;
  bit [7:0]  exp_m = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit be_bit(int i, int p);
    if (i >= 128) return 0;
    return be_m[i/8][(7-(i%8))*8+p];
  endfunction

  function automatic bit [31:0] crc_step(bit [31:0] c, bit [7:0] d);
    bit [31:0] r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic int span_of(int p);
    int l = (len_m[p] > 128) ? 128 : len_m[p];
    return ((l + 7) / 8) * 8;
  endfunction

  function automatic bit [31:0] crc_run(int p, bit use_pat);
    bit [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < span_of(p); i++) begin
      bit [7:0] b = use_pat ? pat[p][i] : frame[i];
      c = crc_step(c, be_bit(i, p) ? b : 8'h00);
    end
    return ~c;
  endfunction

  function automatic bit [7:0] model_hits(int n);
    bit [7:0] h = 0;
    for (int p = 0; p < 8; p++)
      if (span_of(p) != 0 && n >= span_of(p) && crc_run(p, 0) == crc_m[p]) h[p] = 1;
    return h;
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic program_all();
    for (int p = 0; p < 8; p++) begin
      wr(6'h08 + 6'(p), 32'(len_m[p]));
      wr(6'h10 + 6'(p), crc_m[p]);
    end
    for (int w = 0; w < 16; w++) begin
      wr(6'h20 + 6'(2*w), be_m[w][31:0]);
      wr(6'h21 + 6'(2*w), be_m[w][63:32]);
    end
  endtask

  task automatic gen_pattern(int p, int l, bit all_on);
    for (int i = 0; i < 128; i++) be_m[i/8][(7-(i%8))*8+p] = 0;
    for (int i = 0; i < 256; i++) pat[p][i] = 8'($urandom);
    for (int i = 0; i < l; i++)
      be_m[i/8][(7-(i%8))*8+p] = all_on || (i == l-1) || ($urandom % 2 == 1);
    len_m[p] = l;
    crc_m[p] = crc_run(p, 1);
  endtask

  task automatic make_match(int q, int n);
    for (int i = 0; i < n; i++) frame[i] = be_bit(i, q) ? pat[q][i] : 8'($urandom);
  endtask

  task automatic make_random(int n);
    for (int i = 0; i < n; i++) frame[i] = 8'($urandom);
  endtask

  task automatic send_frame(int n, bit with_eof);
    for (int i = 0; i < n; i++) begin
      rx_valid_i = 1; rx_sof_i = (i == 0); rx_eof_i = with_eof && (i == n-1);
      rx_data_i = frame[i];
      @(negedge clk_i);
    end
    rx_valid_i = 0; rx_sof_i = 0; rx_eof_i = 0;
  endtask

  task automatic run_frame(string tag, int n);
    bit [7:0] h;
    send_frame(n, 1);
    h = model_hits(n);
    if (en_m) exp_m |= h;
    chk({tag, " matched"}, 32'(matched_o), 32'(exp_m));
    chk({tag, " wake"}, 32'(wake_o), 32'(en_m && (|h)));
    @(negedge clk_i);
    chk({tag, " wake one cycle"}, 32'(wake_o), 0);
  endtask

  task automatic clear_m();
    wr(6'h01, 0);
    exp_m = 0;
    chk("R7 clear", 32'(matched_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int q, n, s;
    void'($urandom(32'd7321));
    for (int w = 0; w < 16; w++) be_m[w] = 0;
    for (int p = 0; p < 8; p++) begin len_m[p] = 0; crc_m[p] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset wake", 32'(wake_o), 0);
    chk("R1 reset matched", 32'(matched_o), 0);
    // R1: all-zero state with disable: a frame does nothing
    make_random(16);
    run_frame("R1 idle frame", 16);

    for (int p = 0; p < 8; p++) gen_pattern(p, 1 + ($urandom % 128), 0);
    program_all();
    wr(6'h00, 1); en_m = 1;   // R10 enable

    for (int p = 0; p < 8; p++) begin
      clear_m();
      n = span_of(p) + ($urandom % 12);
      make_match(p, n);
      run_frame("R2 R3 slot match", n);
      chk("R3 own bit set", 32'(matched_o[p]), 1);
    end

    // R2: corrupt one enabled byte -> miss; change disabled bytes only -> hit
    for (int p = 0; p < 8; p++) begin
      clear_m();
      n = span_of(p);
      make_match(p, n);
      s = len_m[p] - 1;
      frame[s] = frame[s] ^ 8'h5A;
      run_frame("R2 corrupt", n);
      chk("R2 corrupt miss", 32'(matched_o[p]), 0);
    end
    clear_m();
    gen_pattern(2, 20, 0);
    be_m[0][(7-1)*8+2] = 0; crc_m[2] = crc_run(2, 1);
    program_all();
    make_match(2, 24); frame[1] = ~pat[2][1];
    run_frame("R2 disabled byte forced zero", 24);
    chk("R2 disabled byte hit", 32'(matched_o[2]), 1);

    // R4: length 5 -> span 8
    clear_m();
    gen_pattern(0, 5, 1);
    program_all();
    make_match(0, 8);
    run_frame("R4 short", 7);
    chk("R4 short miss", 32'(matched_o[0]), 0);
    run_frame("R4 full span", 8);
    chk("R4 full span hit", 32'(matched_o[0]), 1);

    // R5: zero length slot
    clear_m();
    n = span_of(7);
    make_match(7, n + 4);
    len_m[7] = 0; wr(6'h0F, 0);
    run_frame("R5 zero length", n + 4);
    chk("R5 zero length miss", 32'(matched_o[7]), 0);

    // R8: length 128 and 200, 200-byte frames
    clear_m();
    gen_pattern(1, 128, 0);
    program_all();
    make_match(1, 200);
    run_frame("R8 len128", 200);
    chk("R8 len128 hit", 32'(matched_o[1]), 1);
    clear_m();
    len_m[1] = 200; wr(6'h09, 200);
    make_match(1, 200);
    run_frame("R8 len200", 200);
    chk("R8 len200 hit", 32'(matched_o[1]), 1);

    // R7 accumulate
    clear_m();
    make_match(3, span_of(3)); run_frame("R7 first", span_of(3));
    make_match(4, span_of(4)); run_frame("R7 second", span_of(4));
    chk("R7 both kept", 32'(matched_o[3] & matched_o[4]), 1);

    // R6 disabled
    wr(6'h00, 0); en_m = 0;
    make_match(5, span_of(5)); run_frame("R6 disabled", span_of(5));
    chk("R6 bit5 untouched", 32'(matched_o[5]), 32'(exp_m[5]));
    wr(6'h00, 1); en_m = 1;

    // R9 abandoned frame
    clear_m();
    make_match(6, span_of(6));
    send_frame(span_of(6), 0);
    @(negedge clk_i);
    chk("R9 no eof no update", 32'(matched_o), 0);
    make_random(10);
    run_frame("R9 restart", 10);

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom % 4 == 0) clear_m();
      q = $urandom % 8;
      case ($urandom % 3)
        0: begin n = span_of(q) + ($urandom % 20); if (n == 0) n = 1; make_match(q, n); end
        1: begin n = 1 + ($urandom % 160); make_random(n); end
        default: begin n = 1 + ($urandom % (span_of(q) + 1)); make_match(q, n); end
      endcase
      run_frame("R2 R4 R10 random", n);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule